// File: doc/BRIEF.md
# IR Transmit Pulse-Width Sequencer

This block plays out a queue of pulse descriptors as a timed mark/space waveform for an infrared transmitter. Each descriptor pairs a one-bit level with an unsigned duration counted in transmit-clock ticks. Descriptors enter through a valid/ready write port into a small FIFO. The sequencer takes the oldest descriptor, drives its level and counts its duration down. It then moves to the next descriptor with no gap.

Time advances only on single-cycle `tick` strobes from an external divider, and only while `enable` is high. A zero duration does not mean "no time". It stands for the longest pulse the duration field can express, which is 2^CNT_W ticks (65536 at the default width). When the queue runs dry, the output falls back to the space level (0) and `busy` drops.

The write port follows valid/ready rules. A beat transfers on a clock edge where `wr_valid` and `wr_ready` are both high, and `wr_ready` is low exactly when the FIFO is full. The source is not required to hold a beat while `wr_ready` is low. Any beat offered in that state is discarded, and the sticky `overflow` flag records the loss.

Top module: `ir_tx_seq`

## Requirements
- R1: A beat with `wr_valid` high while `wr_ready` is high is stored. `wr_ready` goes low once DEPTH descriptors are held and no pop has occurred. `full` mirrors not-ready, and `empty` is high only when no descriptor is held.
- R2: Each stored descriptor is the pair (`wr_level`, `wr_count`). The level is driven on `tx_level` while that descriptor is being played.
- R3: A descriptor with a nonzero count N holds its level on `tx_level` for exactly N tick periods.
- R4: A descriptor with count zero holds its level for exactly 2^CNT_W tick periods.
- R5: Descriptors play in write order. The next one is loaded on the same tick that ends the current one, so no idle tick separates them.
- R6: When the current pulse ends and the FIFO is empty, `tx_level` returns to 0 and `busy` goes low on that tick. While `busy` is low, `tx_level` is 0.
- R7: Ticks that arrive while `enable` is low have no effect. No descriptor is popped, no count advances, and `tx_level`, `busy` and `empty` keep their values.
- R8: A beat offered while `wr_ready` is low is dropped and does not appear in the output waveform. `overflow` goes high and stays high until reset.
- R9: After reset, `tx_level`=0, `busy`=0, `empty`=1, `full`=0, `overflow`=0 and `wr_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Lets ticks advance the sequencer |
| tick | input | 1 | One-cycle transmit-clock strobe from the divider |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | FIFO can accept a beat (not full) |
| wr_level | input | 1 | Level of the offered descriptor |
| wr_count | input | CNT_W | Duration in ticks, 0 meaning 2^CNT_W |
| tx_level | output | 1 | Current mark/space level to the modulator |
| busy | output | 1 | A descriptor is being played |
| empty | output | 1 | FIFO holds no descriptor |
| full | output | 1 | FIFO holds DEPTH descriptors |
| overflow | output | 1 | Sticky: a beat was dropped while full |

## Verification
The bench builds the block with CNT_W=4 and DEPTH=4. At that size, every duration code from 0 to 15 can be swept with both levels, including the zero code that expands to 16 ticks. Filling the four-entry FIFO to overflow takes only a handful of writes. Run lengths are measured in clock cycles and compared with the code times the fixed tick period. This covers back-to-back loading and the return to idle.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  typedef enum logic {
    LVL_SPACE = 1'b0,
    LVL_MARK  = 1'b1
  } ir_level_e;
endpackage

// File: rtl/ir_tx_fifo.sv
module ir_tx_fifo #(
  parameter int WIDTH = 17,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             head_valid,
  output logic             full,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full       = (count == CW'(DEPTH));
  assign head_valid = (count != '0);
  assign push_ready = !full;
  assign do_push    = push_valid && !full;
  assign do_pop     = pop && head_valid;
  assign head_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
      if (push_valid && full) overflow <= 1'b1;
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_drop_keeps_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop) |=> full);
endmodule

// File: rtl/ir_tx_timer.sv
module ir_tx_timer
  import ir_tx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             head_valid,
  input  logic             head_level,
  input  logic [CNT_W-1:0] head_count,
  output logic             pop,
  output logic             level,
  output logic             active
);
  localparam int TIMER_W = CNT_W + 2;
  localparam logic [TIMER_W-1:0] FULL_SPAN = TIMER_W'(1) << CNT_W;

  logic [TIMER_W-1:0] remain, load_val;
  ir_level_e          level_q;
  logic               expire;

  assign load_val = (head_count == '0) ? FULL_SPAN : TIMER_W'(head_count);
  assign expire   = !active || (remain == TIMER_W'(1));
  assign pop      = adv && expire && head_valid;
  assign level    = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      active  <= 1'b0;
      level_q <= LVL_SPACE;
    end else if (adv && expire) begin
      if (head_valid) begin
        remain  <= load_val;
        active  <= 1'b1;
        level_q <= ir_level_e'(head_level);
      end else begin
        remain  <= '0;
        active  <= 1'b0;
        level_q <= LVL_SPACE;
      end
    end else if (adv) begin
      remain <= remain - TIMER_W'(1);
    end
  end

  assert_idle_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (level == 1'b0));
  assert_span_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (remain >= TIMER_W'(1) && remain <= FULL_SPAN));
  assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && head_count == '0) |=> (remain == FULL_SPAN));
  assert_no_tick_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(level) && $stable(remain) && $stable(active)));
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_level,
  input  logic [CNT_W-1:0] wr_count,
  output logic             tx_level,
  output logic             busy,
  output logic             empty,
  output logic             full,
  output logic             overflow
);
  localparam int ENTRY_W = CNT_W + 1;

  logic [ENTRY_W-1:0] head;
  logic               head_valid, pop, adv;

  assign adv   = tick && enable;
  assign empty = !head_valid;

  ir_tx_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (wr_valid),
    .push_ready (wr_ready),
    .push_data  ({wr_level, wr_count}),
    .pop        (pop),
    .head_data  (head),
    .head_valid (head_valid),
    .full       (full),
    .overflow   (overflow)
  );

  ir_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (adv),
    .head_valid (head_valid),
    .head_level (head[CNT_W]),
    .head_count (head[CNT_W-1:0]),
    .pop        (pop),
    .level      (tx_level),
    .active     (busy)
  );

  assert_ready_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready == !full);
  assert_pop_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !full) |=> (empty == $past(empty) || !empty));
endmodule

// File: tb/ir_tx_seq_test.sv
module ir_tx_seq_test;
  localparam int CW = 4;
  localparam int DP = 4;
  localparam int TP = 2;

  logic clk = 0, rst_n = 0, enable = 0, tick = 0, tick_en = 0, ph = 0;
  logic wr_valid = 0, wr_level = 0;
  logic [CW-1:0] wr_count = '0;
  logic wr_ready, tx_level, busy, empty, full, overflow;

  int checks = 0, fails = 0;
  int run_len [16];
  logic run_lvl [16];
  int nruns;

  ir_tx_seq #(.CNT_W(CW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_level(wr_level),
    .wr_count(wr_count), .tx_level(tx_level), .busy(busy), .empty(empty),
    .full(full), .overflow(overflow));

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (tick_en) begin ph = !ph; tick = ph; end
    else begin ph = 0; tick = 0; end
  end

  function automatic int span(input int c);
    return (c == 0) ? (1 << CW) : c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic lv, input int c);
    wr_valid = 1; wr_level = lv; wr_count = CW'(c);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic drain();
    int guard = 0;
    nruns = 0;
    while (!busy && guard < 200) begin @(negedge clk); guard++; end
    while (busy && guard < 3000) begin
      if (nruns == 0 || run_lvl[nruns-1] != tx_level) begin
        if (nruns < 16) begin
          run_lvl[nruns] = tx_level; run_len[nruns] = 0; nruns++;
        end
      end
      run_len[nruns-1] += 1;
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(tx_level == 0 && busy == 0, "R9 level/busy", {tx_level, busy}, 0);
    check(empty == 1 && full == 0, "R9 empty/full", {empty, full}, 2);
    check(overflow == 0 && wr_ready == 1, "R9 overflow/ready", {overflow, wr_ready}, 1);
    rst_n = 1;
    @(negedge clk);
    enable = 1;

    // R3 R4 R5 R2 R6: sweep every code with both levels
    for (int c = 0; c < (1 << CW); c++) begin
      push(1'b1, c);
      push(1'b0, (1 << CW) - 1 - c);
      check(empty == 0, "R1 not empty after push", empty, 0);
      tick_en = 1;
      drain();
      tick_en = 0;
      check(nruns == 2, "R5 run count", nruns, 2);
      check(run_lvl[0] == 1 && run_len[0] == span(c) * TP,
            (c == 0) ? "R4 zero code mark span" : "R3 mark span", run_len[0], span(c) * TP);
      check(run_lvl[1] == 0 && run_len[1] == span((1 << CW) - 1 - c) * TP,
            "R2 space level span", run_len[1], span((1 << CW) - 1 - c) * TP);
      check(tx_level == 0 && empty == 1, "R6 idle after drain", {tx_level, empty}, 1);
      @(negedge clk);
    end

    // R1 R8: fill, overflow, drain
    push(1'b1, 2); push(1'b0, 3); push(1'b1, 4); push(1'b0, 5);
    check(full == 1 && wr_ready == 0, "R1 full after DEPTH", {full, wr_ready}, 2);
    check(overflow == 0, "R8 no overflow yet", overflow, 0);
    push(1'b1, 6);
    check(overflow == 1, "R8 overflow set", overflow, 1);
    tick_en = 1;
    drain();
    tick_en = 0;
    check(nruns == 4, "R8 dropped beat absent", nruns, 4);
    for (int i = 0; i < 4; i++)
      check(run_len[i] == (i + 2) * TP && run_lvl[i] == ((i % 2) == 0),
            "R5 order after fill", run_len[i], (i + 2) * TP);
    check(overflow == 1, "R8 overflow sticky", overflow, 1);
    check(wr_ready == 1 && full == 0, "R1 ready after drain", {wr_ready, full}, 2);

    // R7: ticks ignored while disabled
    enable = 0;
    push(1'b1, 3);
    tick_en = 1;
    repeat (20) @(negedge clk);
    check(busy == 0 && tx_level == 0, "R7 no start when disabled", {busy, tx_level}, 0);
    check(empty == 0, "R7 entry not popped", empty, 0);
    enable = 1;
    drain();
    tick_en = 0;
    check(nruns == 1 && run_len[0] == 3 * TP, "R7 resumes with full span", run_len[0], 3 * TP);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule